// File: doc/BRIEF.md
# Cascaded Secondary Interrupt Controller

This block gathers a group of interrupt source lines and presents them to a primary interrupt controller as one cascade request. Each source can be set up on its own as level-sensitive or edge-triggered, and as active-high/rising or active-low/falling. Edge events are caught in per-source latches. Level sources pass straight through after synchronisation. An enable mask then gates both kinds into a status word, and the OR of that word drives the cascade output.

Software owns the block through a small synchronous register port. When the cascade output is asserted, software reads the status word to find which source needs service. It acknowledges an edge source by writing a one to that bit of the clear register. The enable mask can be written whole, or bits can be set or cleared atomically through two alias addresses, so no read-modify-write sequence is needed. A separate wake mask takes the place of the enable mask while the sleep input is high. This lets only wake-capable sources raise the cascade output during sleep.

Top module: `sec_irq_ctrl`

## Requirements
- R1: After reset, the polarity, type, enable and wake masks read as zero, all edge latches are empty, and `cascade_irq` is low.
- R2: With type bit 0 and polarity bit 0, an enabled source is pending while its input is high, and stops being pending when its input returns low. The status bit is visible two clock edges after the input changes.
- R3: Polarity bit 1 inverts the source. In level mode the source is pending while its input is low. In edge mode a falling edge is latched and a rising edge is not.
- R4: With type bit 1, an active edge on the synchronised input sets that source's latch on the third clock edge after the input changes. The latch holds after the input returns to idle, until it is cleared.
- R5: A write to enable-set (address 4) ORs the written ones into the enable mask. A write to enable-clear (address 5) clears the mask bits where the written word has ones. Reads of either address return the current enable mask.
- R6: A write to enable (address 3) replaces the whole mask. A pending source whose mask bit is 0 shows no status bit and does not raise `cascade_irq`, but its edge latch is kept and appears once the bit is enabled again.
- R7: Writing a one to a bit of clear (address 6) empties that edge latch. On a level source such a write has no lasting effect. Clear always reads as zero.
- R8: If a new edge and a clear write for the same source fall on the same clock edge, the latch ends set.
- R9: `cascade_irq` is high exactly when the status word (address 0) is nonzero.
- R10: While `sleep` is high, the wake mask (address 7) gates the sources in place of the enable mask. A source that is enabled but not wake-capable cannot raise `cascade_irq`.
- R11: The addresses are 0 status (read only), 1 polarity, 2 type, 3 enable, 4 enable-set, 5 enable-clear, 6 clear, 7 wake mask. Bit n of each register belongs to source n. Read data appears on `reg_rdata` the cycle after `reg_rd` is sampled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_in | input | NUM_SRC | Asynchronous interrupt source lines |
| sleep | input | 1 | Selects the wake mask instead of the enable mask |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Register address |
| reg_wdata | input | NUM_SRC | Write data |
| reg_rdata | output | NUM_SRC | Registered read data |
| cascade_irq | output | 1 | Request to the primary controller |

## Verification
A corrupted edge latch shows up on `cascade_irq` and in the status read one cycle after the bad update. A lost edge is caught at the latch update itself, three edges after the input moved. A wrong enable or wake mask bit shows as a status bit that is present or missing at once, in the same cycle as the mask change. The latch-versus-clear race and the polarity handling are checked cycle by cycle at the ports, because a mistake there leaves a stale or missing pending bit that no later traffic would hide.

// File: rtl/sec_irq_ctrl.sv
module sec_irq_ctrl #(
  parameter int NUM_SRC = 32,
  parameter int ADDR_W  = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_in,
  input  logic               sleep,
  input  logic               reg_wr,
  input  logic               reg_rd,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [NUM_SRC-1:0] reg_wdata,
  output logic [NUM_SRC-1:0] reg_rdata,
  output logic               cascade_irq
);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_POL  = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_TYPE = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_EN   = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] A_SET  = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] A_CLR  = ADDR_W'(5);
  localparam logic [ADDR_W-1:0] A_ACK  = ADDR_W'(6);
  localparam logic [ADDR_W-1:0] A_WAKE = ADDR_W'(7);

  logic [NUM_SRC-1:0] sync1_q, sync2_q, prev_q;
  logic [NUM_SRC-1:0] pol_q, type_q, en_q, wake_q, edge_q;
  logic [NUM_SRC-1:0] lvl, edge_det, ack_vec, pend, mask, status;

  wire wr_pol  = reg_wr && reg_addr == A_POL;
  wire wr_type = reg_wr && reg_addr == A_TYPE;
  wire wr_en   = reg_wr && reg_addr == A_EN;
  wire wr_set  = reg_wr && reg_addr == A_SET;
  wire wr_clr  = reg_wr && reg_addr == A_CLR;
  wire wr_ack  = reg_wr && reg_addr == A_ACK;
  wire wr_wake = reg_wr && reg_addr == A_WAKE;

  assign lvl         = sync2_q ^ pol_q;
  assign edge_det    = type_q & lvl & ~(prev_q ^ pol_q);
  assign ack_vec     = wr_ack ? reg_wdata : '0;
  assign pend        = (type_q & edge_q) | (~type_q & lvl);
  assign mask        = sleep ? wake_q : en_q;
  assign status      = pend & mask;
  assign cascade_irq = |status;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= '0;
      sync2_q <= '0;
      prev_q  <= '0;
    end else begin
      sync1_q <= src_in;
      sync2_q <= sync1_q;
      prev_q  <= sync2_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pol_q  <= '0;
      type_q <= '0;
      wake_q <= '0;
      en_q   <= '0;
      edge_q <= '0;
    end else begin
      if (wr_pol)  pol_q  <= reg_wdata;
      if (wr_type) type_q <= reg_wdata;
      if (wr_wake) wake_q <= reg_wdata;
      if (wr_en)       en_q <= reg_wdata;
      else if (wr_set) en_q <= en_q | reg_wdata;
      else if (wr_clr) en_q <= en_q & ~reg_wdata;
      edge_q <= (edge_q & ~ack_vec) | edge_det;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg_rdata <= '0;
    end else if (reg_rd) begin
      case (reg_addr)
        A_STAT:               reg_rdata <= status;
        A_POL:                reg_rdata <= pol_q;
        A_TYPE:               reg_rdata <= type_q;
        A_EN, A_SET, A_CLR:   reg_rdata <= en_q;
        A_WAKE:               reg_rdata <= wake_q;
        default:              reg_rdata <= '0;
      endcase
    end
  end

  // R5
  en_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_set |=> (($past(reg_wdata) & ~en_q) == '0));
  // R5
  en_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_clr |=> (($past(reg_wdata) & en_q) == '0));
  // R4
  latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((($past(edge_q) & ~$past(ack_vec)) & ~edge_q) == '0));
  // R7
  ack_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ack |=> ((edge_q & $past(reg_wdata) & ~$past(edge_det)) == '0));
  // R8
  edge_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(edge_det) & ~edge_q) == '0));
  // R10
  sleep_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep && wake_q == '0) |-> !cascade_irq);
  // R9
  cascade_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cascade_irq |-> (sleep ? (wake_q != '0) : (en_q != '0)));
endmodule

// File: tb/test_sec_irq_ctrl.sv
module test_sec_irq_ctrl;
  localparam int N = 32;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] src_in = '0;
  logic sleep = 1'b0;
  logic reg_wr = 1'b0;
  logic reg_rd = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [N-1:0] reg_wdata = '0;
  logic [N-1:0] reg_rdata;
  logic cascade_irq;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  sec_irq_ctrl #(.NUM_SRC(N), .ADDR_W(3)) i_sec_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .src_in(src_in), .sleep(sleep),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cascade_irq(cascade_irq));

  task automatic check(string req, logic [N-1:0] got, logic [N-1:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [2:0] a, logic [N-1:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd(logic [2:0] a, output logic [N-1:0] d);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic t_reset;
    logic [N-1:0] d;
    for (int a = 1; a < 8; a++) begin
      rd(3'(a), d);
      check("R1 reset read", d, '0);
    end
    check("R1 cascade after reset", {31'b0, cascade_irq}, '0);
  endtask

  task automatic t_level;
    logic [N-1:0] d;
    wr(3, 32'h0000_0001);
    src_in[0] = 1'b1;
    cyc(1);
    check("R2 level not yet visible", {31'b0, cascade_irq}, '0);
    cyc(1);
    check("R2 level at second edge", {31'b0, cascade_irq}, 1);
    rd(0, d);
    check("R11 status bit 0", d, 32'h1);
    src_in[0] = 1'b0;
    cyc(3);
    check("R2 level drops", {31'b0, cascade_irq}, '0);
    wr(3, '0);
  endtask

  task automatic t_polarity;
    logic [N-1:0] d;
    wr(1, 32'h0000_0006);
    wr(2, 32'h0000_0004);
    wr(3, 32'h0000_0006);
    cyc(3);
    rd(0, d);
    check("R3 active-low level idle high input", d, 32'h2);
    src_in[1] = 1'b1; src_in[2] = 1'b1;
    cyc(4);
    rd(0, d);
    check("R3 rising edge ignored on falling source", d, 32'h0);
    src_in[2] = 1'b0;
    cyc(4);
    src_in[2] = 1'b1;
    cyc(3);
    rd(0, d);
    check("R3 falling edge latched", d, 32'h4);
    wr(6, 32'h4);
    cyc(1);
    src_in[1] = 1'b0; src_in[2] = 1'b0;
    wr(3, '0); wr(1, '0); wr(2, '0);
    cyc(4);
  endtask

  task automatic t_edge;
    logic [N-1:0] d;
    wr(2, 32'h0000_0100);
    wr(3, 32'h0000_0100);
    src_in[8] = 1'b1;
    cyc(2);
    check("R4 not latched at second edge", {31'b0, cascade_irq}, '0);
    cyc(1);
    check("R4 latched at third edge", {31'b0, cascade_irq}, 1);
    src_in[8] = 1'b0;
    cyc(5);
    rd(0, d);
    check("R4 latch holds", d, 32'h100);
    wr(6, 32'h100);
    cyc(1);
    check("R7 clear empties latch", {31'b0, cascade_irq}, '0);
    rd(6, d);
    check("R7 clear reads zero", d, '0);
  endtask

  task automatic t_enable_ops;
    logic [N-1:0] d;
    wr(3, 32'h0000_00F0);
    wr(4, 32'h0000_0F00);
    rd(4, d);
    check("R5 set ORs, read via set alias", d, 32'h0000_0FF0);
    wr(5, 32'h0000_0330);
    rd(5, d);
    check("R5 clear alias", d, 32'h0000_0CC0);
    wr(3, 32'h8000_0000);
    rd(3, d);
    check("R6 direct write replaces", d, 32'h8000_0000);
  endtask

  task automatic t_mask;
    logic [N-1:0] d;
    wr(3, '0);
    wr(2, 32'h0000_0100);
    src_in[8] = 1'b1;
    cyc(4);
    check("R6 masked edge no cascade", {31'b0, cascade_irq}, '0);
    rd(0, d);
    check("R9 status zero when masked", d, '0);
    src_in[8] = 1'b0;
    wr(4, 32'h0000_0100);
    check("R6 latch appears after enable", {31'b0, cascade_irq}, 1);
    wr(6, 32'h100);
    wr(3, '0);
    wr(2, '0);
  endtask

  task automatic t_level_clear;
    logic [N-1:0] d;
    wr(3, 32'h0000_0010);
    src_in[4] = 1'b1;
    cyc(3);
    wr(6, 32'h0000_0010);
    cyc(1);
    rd(0, d);
    check("R7 clear on level source no effect", d, 32'h10);
    check("R9 cascade with nonzero status", {31'b0, cascade_irq}, 1);
    src_in[4] = 1'b0;
    wr(3, '0);
    cyc(3);
  endtask

  task automatic t_edge_vs_clear;
    logic [N-1:0] d;
    wr(2, 32'h0000_0020);
    wr(3, 32'h0000_0020);
    src_in[5] = 1'b1;
    cyc(4);
    src_in[5] = 1'b0;
    cyc(4);
    src_in[5] = 1'b1;
    cyc(2);
    wr(6, 32'h0000_0020);
    rd(0, d);
    check("R8 edge wins over clear", d, 32'h20);
    src_in[5] = 1'b0;
    wr(6, 32'h20);
    wr(3, '0);
    wr(2, '0);
    cyc(3);
  endtask

  task automatic t_sleep;
    logic [N-1:0] d;
    wr(3, 32'h0000_0002);
    wr(7, 32'h0000_0004);
    src_in[1] = 1'b1; src_in[2] = 1'b1;
    cyc(3);
    rd(0, d);
    check("R10 awake uses enable", d, 32'h2);
    sleep = 1'b1;
    rd(0, d);
    check("R10 asleep uses wake mask", d, 32'h4);
    wr(7, '0);
    check("R10 asleep no wake source", {31'b0, cascade_irq}, '0);
    rd(7, d);
    check("R11 wake readback", d, '0);
    sleep = 1'b0;
    src_in = '0;
    wr(3, '0);
  endtask

  initial begin
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
    t_reset();
    t_level();
    t_polarity();
    t_edge();
    t_enable_ops();
    t_mask();
    t_level_clear();
    t_edge_vs_clear();
    t_sleep();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule